// File: doc/BRIEF.md
# Per-Line Sprite Evaluator

This block holds the sprite attribute table of a tile-based video generator. The table has 64 entries of four bytes each. Once per scanline it walks that table and picks the sprites that cover the line about to be drawn. For each chosen sprite it produces a record. The record carries the horizontal position and the attribute byte unchanged, a flag marking the record that came from entry 0, and the 13-bit pattern-memory address of the sprite row that falls on that line.

A pulse on `eval_start` begins a pass over all 64 entries, one entry per clock. A one-cycle `done` pulse marks the end of the pass, and at that point the record list is valid for a downstream pattern fetcher. Sprites can be 8 or 16 pixels tall. The list holds at most eight records. Any further sprite found on the same line sets a sticky overflow flag and is discarded. The host fills the table through a byte-wide write port. It pulses `vblank_end` when vertical blanking finishes, which clears the list and the overflow flag.

Top module: `sprite_line_eval`

## Requirements
- R1: An entry is selected for line L only if 0 <= L - Y < H and Y < 240. H is 8, or 16 when `tall_mode` is 1. Y is the entry's byte 0.
- R2: A pass keeps at most 8 records. Every further in-range entry is dropped and sets `overflow`. `overflow` then stays 1 across later passes until `vblank_end`.
- R3: When `tall_mode` is 0, the record address is `base_sel`*0x1000 + tile*16 + r. Here r = L - Y, replaced by 7 - r when attribute bit 7 is 1.
- R4: When `tall_mode` is 1, let r = L - Y, replaced by 15 - r when attribute bit 7 is 1. The address is (tile bit 0)*0x1000 + (tile with bit 0 cleared)*16 + r, with 8 added to r when r > 7. `base_sel` has no effect in this mode.
- R5: Entries are examined in increasing index. Entry i sits at table bytes 4i (Y), 4i+1 (tile), 4i+2 (attribute) and 4i+3 (X), written via `oam_we`/`oam_waddr`/`oam_wdata`. Record k holds the k-th selected entry. `list_zero[k]` is 1 only for a record taken from entry 0.
- R6: While `sprites_on` is 0, a pass selects nothing, and `list_count` stays 0 after the pass.
- R7: `vblank_end` clears `list_count` and `overflow` on the next clock and aborts a running pass. An accepted `eval_start` clears `list_count` before the pass begins.
- R8: After the clock edge that accepts `eval_start`, `done` is high for exactly one cycle, after 64 further edges. `eval_start` is ignored while `busy` is 1.
- R9: Record k exposes the entry's X byte on `list_x[8k+7:8k]` and its attribute byte on `list_attr[8k+7:8k]`, both unchanged. It exposes its address on `list_addr[13k+12:13k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| oam_we | input | 1 | Table byte write enable |
| oam_waddr | input | 8 | Table byte address |
| oam_wdata | input | 8 | Table byte data |
| eval_start | input | 1 | Begin a pass (accepted when idle) |
| scan_line | input | 8 | Line being evaluated, held during a pass |
| tall_mode | input | 1 | 1 = 16-pixel-tall sprites |
| base_sel | input | 1 | Selects the upper 4 KiB pattern half for short sprites |
| sprites_on | input | 1 | Sprite enable |
| vblank_end | input | 1 | End-of-blanking pulse |
| list_count | output | 4 | Number of valid records |
| list_x | output | 64 | X bytes of records 0..7 |
| list_attr | output | 64 | Attribute bytes of records 0..7 |
| list_zero | output | 8 | Entry-0 marker per record |
| list_addr | output | 104 | Pattern addresses of records 0..7 |
| overflow | output | 1 | Sticky too-many-sprites flag |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions assume three things about the inputs: `scan_line`, `tall_mode`, `base_sel` and `sprites_on` stay constant for the whole of a pass, `eval_start` is a single-cycle pulse, and the table is not rewritten while a pass runs. The stimulus changes these inputs only between a `done` pulse and the next start. It loads the table only while the block is idle. Its one mid-pass start pulse deliberately lands while `busy` is 1, so that the pulse is shown to be ignored.

// File: rtl/spe_pkg.sv
package spe_pkg;

  localparam int ADDR_W = 13;

  typedef struct packed {
    logic [7:0]        x;
    logic [7:0]        attr;
    logic              zero;
    logic [ADDR_W-1:0] addr;
  } sprite_rec_t;

  // Range test: line lies within [y, y+height) and y is below the visible limit.
  function automatic logic line_hits(input logic [7:0] line, input logic [7:0] y,
                                     input logic tall, input logic [7:0] y_limit);
    logic [8:0] diff;
    diff = {1'b0, line} - {1'b0, y};
    return !diff[8] && (diff[7:0] < (tall ? 8'd16 : 8'd8)) && (y < y_limit);
  endfunction

  // Pattern address of the row of a sprite that falls on the line.
  function automatic logic [ADDR_W-1:0] row_address(input logic [7:0] tile,
                                                    input logic [7:0] attr,
                                                    input logic [3:0] row,
                                                    input logic tall,
                                                    input logic base_sel);
    logic [4:0] tall_row;
    logic [2:0] short_row;
    logic [ADDR_W-1:0] a;
    if (tall) begin
      tall_row = {row[3], 1'b0, row[2:0]};
      if (attr[7]) tall_row = tall_row ^ 5'd23;
      a = {tile[0], 12'd0} + ({5'd0, tile[7:1]} << 5) + {8'd0, tall_row};
    end else begin
      short_row = row[2:0];
      if (attr[7]) short_row = short_row ^ 3'd7;
      a = {base_sel, 12'd0} + ({5'd0, tile} << 4) + {10'd0, short_row};
    end
    return a;
  endfunction

endpackage

// File: rtl/spe_oam_store.sv
module spe_oam_store #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BYTE_W = $clog2(ENTRIES * 4)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       r_y,
  output logic [7:0]       r_tile,
  output logic [7:0]       r_attr,
  output logic [7:0]       r_x
);
  logic [7:0] mem [ENTRIES*4];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    r_y    = mem[{ridx, 2'd0}];
    r_tile = mem[{ridx, 2'd1}];
    r_attr = mem[{ridx, 2'd2}];
    r_x    = mem[{ridx, 2'd3}];
  end
endmodule

// File: rtl/spe_match.sv
module spe_match
  import spe_pkg::*;
#(
  parameter logic [7:0] Y_LIMIT = 8'd240
) (
  input  logic [7:0]        line,
  input  logic [7:0]        y,
  input  logic [7:0]        tile,
  input  logic [7:0]        attr,
  input  logic [7:0]        x,
  input  logic              tall,
  input  logic              base_sel,
  input  logic              is_first,
  output logic              in_range,
  output sprite_rec_t       rec
);
  logic [7:0] row_full;

  always_comb begin
    row_full  = line - y;
    in_range  = line_hits(line, y, tall, Y_LIMIT);
    rec.x     = x;
    rec.attr  = attr;
    rec.zero  = is_first;
    rec.addr  = row_address(tile, attr, row_full[3:0], tall, base_sel);
  end
endmodule

// File: rtl/spe_list.sv
module spe_list
  import spe_pkg::*;
#(
  parameter int MAX_SEL = 8,
  localparam int CNT_W  = $clog2(MAX_SEL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      push,
  input  sprite_rec_t               push_rec,
  output logic                      full,
  output logic [CNT_W-1:0]          count,
  output logic [MAX_SEL*8-1:0]      x_flat,
  output logic [MAX_SEL*8-1:0]      attr_flat,
  output logic [MAX_SEL-1:0]        zero_flat,
  output logic [MAX_SEL*ADDR_W-1:0] addr_flat
);
  sprite_rec_t slots [MAX_SEL];

  assign full = (count == CNT_W'(MAX_SEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (clear)           count <= '0;
    else if (push && !full)   count <= count + 1'b1;
  end

  for (genvar k = 0; k < MAX_SEL; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slots[k] <= '0;
      else if (clear)                               slots[k] <= '0;
      else if (push && count == CNT_W'(k))          slots[k] <= push_rec;
    end
    assign x_flat[k*8 +: 8]            = slots[k].x;
    assign attr_flat[k*8 +: 8]         = slots[k].attr;
    assign zero_flat[k]                = slots[k].zero;
    assign addr_flat[k*ADDR_W +: ADDR_W] = slots[k].addr;
  end
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
  import spe_pkg::*;
#(
  parameter int ENTRIES         = 64,
  parameter int MAX_SEL         = 8,
  parameter logic [7:0] Y_LIMIT = 8'd240,
  localparam int IDX_W          = $clog2(ENTRIES),
  localparam int BYTE_W         = $clog2(ENTRIES * 4),
  localparam int CNT_W          = $clog2(MAX_SEL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      oam_we,
  input  logic [BYTE_W-1:0]         oam_waddr,
  input  logic [7:0]                oam_wdata,
  input  logic                      eval_start,
  input  logic [7:0]                scan_line,
  input  logic                      tall_mode,
  input  logic                      base_sel,
  input  logic                      sprites_on,
  input  logic                      vblank_end,
  output logic [CNT_W-1:0]          list_count,
  output logic [MAX_SEL*8-1:0]      list_x,
  output logic [MAX_SEL*8-1:0]      list_attr,
  output logic [MAX_SEL-1:0]        list_zero,
  output logic [MAX_SEL*ADDR_W-1:0] list_addr,
  output logic                      overflow,
  output logic                      busy,
  output logic                      done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] idx;
  logic [7:0]       e_y, e_tile, e_attr, e_x;
  logic             m_in_range;
  sprite_rec_t      m_rec;
  logic             list_full;

  // Named events for the checker.
  logic hit, store_ev, drop_ev, accept_start, list_clear;

  spe_oam_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .we(oam_we), .waddr(oam_waddr), .wdata(oam_wdata),
    .ridx(idx), .r_y(e_y), .r_tile(e_tile), .r_attr(e_attr), .r_x(e_x)
  );

  spe_match #(.Y_LIMIT(Y_LIMIT)) u_match (
    .line(scan_line), .y(e_y), .tile(e_tile), .attr(e_attr), .x(e_x),
    .tall(tall_mode), .base_sel(base_sel), .is_first(idx == '0),
    .in_range(m_in_range), .rec(m_rec)
  );

  assign accept_start = eval_start && !busy && !vblank_end;
  assign list_clear   = vblank_end || accept_start;
  assign hit          = busy && !vblank_end && sprites_on && m_in_range;
  assign store_ev     = hit && !list_full;
  assign drop_ev      = hit && list_full;

  spe_list #(.MAX_SEL(MAX_SEL)) u_list (
    .clk(clk), .rst_n(rst_n), .clear(list_clear), .push(store_ev),
    .push_rec(m_rec), .full(list_full), .count(list_count),
    .x_flat(list_x), .attr_flat(list_attr), .zero_flat(list_zero),
    .addr_flat(list_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      done <= 1'b0;
      if (vblank_end) begin
        busy     <= 1'b0;
        overflow <= 1'b0;
      end else begin
        if (drop_ev) overflow <= 1'b1;
        if (busy) begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else if (eval_start) begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
  parameter int MAX_SEL = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_start,
  input logic             vblank_end,
  input logic             sprites_on,
  input logic             busy,
  input logic             done,
  input logic             overflow,
  input logic [CNT_W-1:0] list_count,
  input logic             store_ev,
  input logic             drop_ev
);
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    list_count <= CNT_W'(MAX_SEL));

  a_r2_store_only_below_max: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |-> list_count < CNT_W'(MAX_SEL));

  a_r2_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> list_count == CNT_W'(MAX_SEL));

  a_r2_drop_sets_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> overflow);

  a_r2_overflow_rises_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(drop_ev));

  a_r6_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (!sprites_on && !eval_start && !vblank_end) |=> $stable(list_count));

  a_r7_vblank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_end |=> (list_count == '0 && !overflow && !busy));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_start && !busy && !vblank_end) |=> (list_count == '0 && busy));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_ends_pass: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind sprite_line_eval spe_checker #(.MAX_SEL(MAX_SEL), .CNT_W(CNT_W)) u_spe_chk (
  .clk(clk), .rst_n(rst_n), .eval_start(eval_start), .vblank_end(vblank_end),
  .sprites_on(sprites_on), .busy(busy), .done(done), .overflow(overflow),
  .list_count(list_count), .store_ev(store_ev), .drop_ev(drop_ev)
);

// File: tb/test_sprite_line_eval.sv
module test_sprite_line_eval;
  localparam int NE = 64;
  localparam int MS = 8;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oam_we = 1'b0;
  logic [7:0] oam_waddr = '0;
  logic [7:0] oam_wdata = '0;
  logic eval_start = 1'b0;
  logic [7:0] scan_line = '0;
  logic tall_mode = 1'b0;
  logic base_sel = 1'b0;
  logic sprites_on = 1'b1;
  logic vblank_end = 1'b0;
  logic [3:0] list_count;
  logic [MS*8-1:0] list_x, list_attr;
  logic [MS-1:0] list_zero;
  logic [MS*AW-1:0] list_addr;
  logic overflow, busy, done;

  sprite_line_eval i_sprite_line_eval (
    .clk(clk), .rst_n(rst_n), .oam_we(oam_we), .oam_waddr(oam_waddr),
    .oam_wdata(oam_wdata), .eval_start(eval_start), .scan_line(scan_line),
    .tall_mode(tall_mode), .base_sel(base_sel), .sprites_on(sprites_on),
    .vblank_end(vblank_end), .list_count(list_count), .list_x(list_x),
    .list_attr(list_attr), .list_zero(list_zero), .list_addr(list_addr),
    .overflow(overflow), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int ovf_model = 0;
  int ty [NE];
  int tt [NE];
  int ta [NE];
  int tx [NE];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=below 190000", cycles);
      finish_run();
    end
  end

  task automatic write_table();
    for (int i = 0; i < NE; i++) begin
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        oam_we = 1'b1;
        oam_waddr = 8'(i*4 + b);
        oam_wdata = 8'(b == 0 ? ty[i] : b == 1 ? tt[i] : b == 2 ? ta[i] : tx[i]);
      end
    end
    @(negedge clk);
    oam_we = 1'b0;
  endtask

  function automatic int expect_addr(input int t, input int a, input int d);
    int r;
    int flip = (a >= 128) ? 1 : 0;
    if (tall_mode) begin
      r = flip ? 15 - d : d;
      if (r >= 8) r = r + 8;
      return (t % 2) * 4096 + (t / 2) * 32 + r;
    end
    r = flip ? 7 - d : d;
    return (base_sel ? 4096 : 0) + t * 16 + r;
  endfunction

  // Runs one pass on a line and compares against the arithmetic model.
  task automatic run_line(input int line, input int poke_at);
    int n = 0;
    int hits = 0;
    int h = tall_mode ? 16 : 8;
    int ex_idx [MS];
    @(negedge clk);
    scan_line = 8'(line);
    eval_start = 1'b1;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      eval_start = (poke_at != 0 && n == poke_at);
    end while (!done && n < 200);
    eval_start = 1'b0;
    check("R8", "done latency", n, NE + 1);
    for (int i = 0; i < NE; i++) begin
      int d = line - ty[i];
      if (sprites_on && d >= 0 && d < h && ty[i] < 240) begin
        if (hits < MS) ex_idx[hits] = i;
        else ovf_model = 1;
        hits++;
      end
    end
    check(sprites_on ? "R1" : "R6", "list count", list_count, hits > MS ? MS : hits);
    check("R2", "overflow", overflow, ovf_model);
    for (int k = 0; k < MS && k < hits; k++) begin
      int e = ex_idx[k];
      check(tall_mode ? "R4" : "R3", "address", list_addr[k*AW +: AW],
            expect_addr(tt[e], ta[e], line - ty[e]));
      check("R9", "x byte", list_x[k*8 +: 8], tx[e]);
      check("R9", "attr byte", list_attr[k*8 +: 8], ta[e]);
      check("R5", "entry-0 marker", list_zero[k], e == 0 ? 1 : 0);
    end
    @(negedge clk);
    check("R8", "done width", done, 0);
  endtask

  task automatic pulse_vblank();
    @(negedge clk);
    vblank_end = 1'b1;
    @(negedge clk);
    vblank_end = 1'b0;
    ovf_model = 0;
    check("R7", "count after vblank", list_count, 0);
    check("R7", "overflow after vblank", overflow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "reset count", list_count, 0);
    check("R2", "reset overflow", overflow, 0);
    check("R8", "reset done", done, 0);
    rst_n = 1'b1;

    // Spread table: about two sprites per line, some Y at or above 240.
    for (int i = 0; i < NE; i++) begin
      ty[i] = (i * 7 + 3) % 256;
      tt[i] = (i * 29 + 5) % 256;
      ta[i] = (i * 83 + 17) % 256;
      tx[i] = (i * 13 + 1) % 256;
    end
    write_table();
    tall_mode = 1'b0; base_sel = 1'b0;
    run_line(3, 10);   // mid-pass start ignored (R8)
    for (int l = 0; l < 256; l++) run_line(l, 0);
    base_sel = 1'b1;
    for (int l = 0; l < 64; l++) run_line(l, 0);
    tall_mode = 1'b1;  // base_sel stays 1: must not matter (R4)
    for (int l = 0; l < 256; l++) run_line(l, 0);

    // Crowded table: entries 0..10 on line 50, the rest at Y >= 240.
    for (int i = 0; i < NE; i++) begin
      ty[i] = (i <= 10) ? 50 : 240 + (i % 16);
      tt[i] = i * 3;
      ta[i] = (i % 2) ? 8'h80 : 8'h03;
      tx[i] = 255 - i;
    end
    write_table();
    tall_mode = 1'b0; base_sel = 1'b0;
    run_line(50, 0);   // R2: 11 hits, 8 kept, overflow set
    run_line(200, 0);  // R2 sticky, R7 start clears list
    run_line(250, 0);  // R1: Y >= 240 never selected
    pulse_vblank();
    sprites_on = 1'b0;
    run_line(50, 0);   // R6
    check("R6", "no overflow when disabled", overflow, 0);
    sprites_on = 1'b1;
    run_line(53, 0);
    pulse_vblank();    // R7: clears a filled list
    tall_mode = 1'b1;
    run_line(60, 0);
    finish_run();
  end
endmodule